// File: doc/BRIEF.md
# Serial-Input FIR Level Classifier

This block collects 10-bit samples that arrive one bit at a time, runs each new sample through a long symmetric FIR filter, and turns the scaled filter output into a three-way indication on two lamps. A sender raises a framing signal, toggles a bit clock once per data bit, and then drops the framing signal. The falling edge of the framing signal starts one filter pass. The bit clock and the framing signal are slow, asynchronous inputs. They are brought into the system clock domain through a short synchronizer chain, and their edges are detected there.

Each pass uses a single multiplier. It performs one multiply-accumulate per system clock, walking the delay line against a coefficient table that is computed at elaboration. When the last tap has been summed, a fixed-point slice of the accumulator is stored as the output level. The lamps follow from that stored level. Between passes the lamps do not move.

Top module: `fir_level_lamps`

## Requirements
- R1: While `frame` is high, every rising edge of `bit_clk` shifts the sample register one place toward bit 0 and loads `bit_in` into bit 9. Bits are therefore sent least significant first. Rising edges of `bit_clk` while `frame` is low leave the register unchanged. A frame carrying fewer than 10 bits keeps the older bits, shifted.
- R2: A falling edge of `frame` starts exactly one filter pass on the current sample register, even when no bits were sent in that frame. Holding `frame` low starts nothing further. A new pass needs `frame` to go high again.
- R3: When a pass is accepted, the sample register enters tap 0, which is the newest position. Every stored sample moves one tap older, and the oldest sample is dropped.
- R4: Tap k uses a signed 17-bit coefficient chosen by m = min(k, NUM_TAPS-1-k). The values are 442 for m=0, -373 for m=1 and -169 for m=2, and INNER_COEF for every other m. The real taps are these values divided by 2^15.
- R5: Samples are unsigned. The 32-bit signed accumulator starts from zero on every pass and adds one coefficient-times-sample product per clock. The level is stored NUM_TAPS+1 clocks after the pass is accepted.
- R6: The level is bits [22:15] of the accumulator, taken as an 8-bit value. Overflow wraps modulo 2^32.
- R7: A level from 90 to 110 inclusive gives `lamp_high`=1 and `lamp_warn`=0. A level from 40 to 60 inclusive gives both lamps 0. Any other level gives `lamp_high`=0 and `lamp_warn`=1. The two lamps are never both on.
- R8: Reset clears the sample register, the delay line and the level. After reset `lamp_warn`=1 and `lamp_high`=0.
- R9: The lamps change only in the clock after a pass stores its level.
- R10: A falling edge of `frame` that arrives while a pass is running is ignored. Nothing enters the delay line and no extra pass is started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_clk | input | 1 | Serial bit clock from the sender; data is taken on its rising edge |
| bit_in | input | 1 | Serial data bit, least significant first |
| frame | input | 1 | High while a sample is being sent; its fall starts a pass |
| lamp_high | output | 1 | On when the level lies in the upper window |
| lamp_warn | output | 1 | On when the level lies outside both windows |

## Verification
Only the lamps are visible, so a wrong coefficient, a stale tap or an uncleared accumulator appears as a wrong lamp pair when the pass ends. That is NUM_TAPS+1 clocks after acceptance, plus the synchronizer delay. A slow ramp of input samples drives the level through every integer near the window edges, so any error in the slice or the windows changes a lamp within a single sample. Errors in the delay line show up once the affected sample meets a non-zero coefficient. They then persist in each later pass until the sample falls off the line.

// File: rtl/fir_lamp_pkg.sv
package fir_lamp_pkg;

    localparam int SAMPLE_W  = 10;
    localparam int COEF_W    = 17;
    localparam int ACC_W     = 32;
    localparam int FRAC_BITS = 15;
    localparam int LEVEL_W   = 8;

    localparam int HIGH_LO = 90;
    localparam int HIGH_HI = 110;
    localparam int MID_LO  = 40;
    localparam int MID_HI  = 60;

    typedef logic [SAMPLE_W-1:0]        sample_t;
    typedef logic signed [COEF_W-1:0]   coef_t;
    typedef logic signed [ACC_W-1:0]    acc_t;
    typedef logic [LEVEL_W-1:0]         level_t;

    typedef enum logic [1:0] {
        MAC_IDLE = 2'd0,
        MAC_RUN  = 2'd1,
        MAC_DONE = 2'd2
    } mac_state_e;

    typedef struct packed {
        logic hi;
        logic warn;
    } lamp_t;

    // Symmetric tap value: the three outermost positions on each side are fixed,
    // all inner positions share one programmable value.
    function automatic coef_t tap_coef(input int k, input int n, input int inner);
        int m;
        m = (k < n - 1 - k) ? k : n - 1 - k;
        case (m)
            0:       return coef_t'(442);
            1:       return coef_t'(-373);
            2:       return coef_t'(-169);
            default: return coef_t'(inner);
        endcase
    endfunction

    function automatic lamp_t classify(input level_t lv);
        lamp_t r;
        int    v;
        v = int'(lv);
        if (v >= HIGH_LO && v <= HIGH_HI) begin
            r.hi   = 1'b1;
            r.warn = 1'b0;
        end else if (v >= MID_LO && v <= MID_HI) begin
            r.hi   = 1'b0;
            r.warn = 1'b0;
        end else begin
            r.hi   = 1'b0;
            r.warn = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/fir_serial_deser.sv
module fir_serial_deser
    import fir_lamp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    bit_clk,
    input  logic    bit_in,
    input  logic    frame,
    output sample_t sample,
    output logic    frame_fall
);

    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0]       bclk_q;
    logic [CHAIN-1:0]       frame_q;
    logic [SYNC_STAGES-1:0] bin_q;
    logic                   bclk_rise;
    logic                   frame_high;

    // The top entry of each chain is one cycle older than the synchronized value,
    // which gives edge detection without a separate register.
    assign bclk_rise  = bclk_q[SYNC_STAGES-1] & ~bclk_q[SYNC_STAGES];
    assign frame_high = frame_q[SYNC_STAGES-1];
    assign frame_fall = frame_q[SYNC_STAGES] & ~frame_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q  <= '0;
            frame_q <= '0;
            bin_q   <= '0;
            sample  <= '0;
        end else begin
            bclk_q  <= CHAIN'({bclk_q, bit_clk});
            frame_q <= CHAIN'({frame_q, frame});
            bin_q   <= SYNC_STAGES'({bin_q, bit_in});
            if (bclk_rise && frame_high) begin
                sample <= {bin_q[SYNC_STAGES-1], sample[SAMPLE_W-1:1]};
            end
        end
    end

endmodule

// File: rtl/fir_tap_line.sv
module fir_tap_line
    import fir_lamp_pkg::*;
#(
    parameter int DEPTH = 465,
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  sample_t          din,
    input  logic [IDX_W-1:0] rd_idx,
    output sample_t          rd_data
);

    sample_t taps [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                taps[i] <= '0;
            end
        end else if (push) begin
            taps[0] <= din;
            for (int i = 1; i < DEPTH; i++) begin
                taps[i] <= taps[i-1];
            end
        end
    end

    assign rd_data = taps[rd_idx];

endmodule

// File: rtl/fir_mac_engine.sv
module fir_mac_engine
    import fir_lamp_pkg::*;
#(
    parameter int NUM_TAPS   = 465,
    parameter int INNER_COEF = 72,
    parameter int IDX_W      = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    output logic [IDX_W-1:0] rd_idx,
    input  sample_t          rd_data,
    output logic             idle,
    output logic             level_load,
    output level_t           level
);

    localparam int               PROD_W = COEF_W + SAMPLE_W + 1;
    localparam logic [IDX_W-1:0] LAST   = IDX_W'(NUM_TAPS - 1);

    mac_state_e               state;
    logic [IDX_W-1:0]         idx;
    acc_t                     acc;
    coef_t                    coef_rom [NUM_TAPS];
    logic signed [PROD_W-1:0] coef_ext;
    logic signed [PROD_W-1:0] samp_ext;
    logic signed [PROD_W-1:0] product;

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_rom
        assign coef_rom[g] = tap_coef(g, NUM_TAPS, INNER_COEF);
    end

    assign coef_ext = PROD_W'(coef_rom[idx]);
    assign samp_ext = PROD_W'($signed({1'b0, rd_data}));
    assign product  = coef_ext * samp_ext;

    assign rd_idx     = idx;
    assign idle       = (state == MAC_IDLE);
    assign level_load = (state == MAC_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= MAC_IDLE;
            idx   <= '0;
            acc   <= '0;
            level <= '0;
        end else begin
            case (state)
                MAC_IDLE: begin
                    if (go) begin
                        state <= MAC_RUN;
                        idx   <= '0;
                        acc   <= '0;
                    end
                end
                MAC_RUN: begin
                    acc <= acc + ACC_W'(product);
                    if (idx == LAST) begin
                        state <= MAC_DONE;
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
                MAC_DONE: begin
                    level <= acc[FRAC_BITS +: LEVEL_W];
                    state <= MAC_IDLE;
                end
                default: state <= MAC_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fir_level_lamps.sv
module fir_level_lamps
    import fir_lamp_pkg::*;
#(
    parameter int NUM_TAPS    = 465,
    parameter int INNER_COEF  = 72,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_clk,
    input  logic bit_in,
    input  logic frame,
    output logic lamp_high,
    output logic lamp_warn
);

    localparam int IDX_W = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1;

    sample_t          cur_sample;
    logic             frame_fall;
    logic             accept;
    logic             mac_idle;
    logic             level_load;
    logic [IDX_W-1:0] rd_idx;
    sample_t          rd_data;
    level_t           level;
    lamp_t            lamps;

    fir_serial_deser #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_deser (
        .clk        (clk),
        .rst        (rst),
        .bit_clk    (bit_clk),
        .bit_in     (bit_in),
        .frame      (frame),
        .sample     (cur_sample),
        .frame_fall (frame_fall)
    );

    // A fall seen while the engine is busy is dropped, so the line stays frozen mid-pass.
    assign accept = frame_fall & mac_idle;

    fir_tap_line #(
        .DEPTH (NUM_TAPS),
        .IDX_W (IDX_W)
    ) u_line (
        .clk     (clk),
        .rst     (rst),
        .push    (accept),
        .din     (cur_sample),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    fir_mac_engine #(
        .NUM_TAPS   (NUM_TAPS),
        .INNER_COEF (INNER_COEF),
        .IDX_W      (IDX_W)
    ) u_mac (
        .clk        (clk),
        .rst        (rst),
        .go         (accept),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data),
        .idle       (mac_idle),
        .level_load (level_load),
        .level      (level)
    );

    assign lamps     = classify(level);
    assign lamp_high = lamps.hi;
    assign lamp_warn = lamps.warn;

endmodule

// File: rtl/fir_level_lamps_chk.sv
module fir_level_lamps_chk #(
    parameter int NUM_TAPS = 465
) (
    input logic clk,
    input logic rst,
    input logic accept,
    input logic mac_idle,
    input logic level_load,
    input logic lamp_high,
    input logic lamp_warn
);

    int run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= 0;
        end else if (accept) begin
            run_cnt <= 1;
        end else if (level_load) begin
            run_cnt <= 0;
        end else if (run_cnt != 0) begin
            run_cnt <= run_cnt + 1;
        end
    end

    a_r7_lamps_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(lamp_high && lamp_warn));

    a_r9_lamps_hold: assert property (@(posedge clk) disable iff (rst)
        !level_load |=> $stable({lamp_high, lamp_warn}));

    a_r5_pass_length: assert property (@(posedge clk) disable iff (rst)
        level_load |-> (run_cnt == NUM_TAPS + 1));

    a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        accept |=> !mac_idle);

    a_r8_reset_lamps: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lamp_warn && !lamp_high));

endmodule

bind fir_level_lamps fir_level_lamps_chk #(
    .NUM_TAPS (NUM_TAPS)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .mac_idle   (mac_idle),
    .level_load (level_load),
    .lamp_high  (lamp_high),
    .lamp_warn  (lamp_warn)
);

// File: tb/test_fir_level_lamps.sv
module test_fir_level_lamps;

    localparam int NT    = 9;
    localparam int INNER = 11000;

    logic clk     = 1'b0;
    logic rst     = 1'b1;
    logic bit_clk = 1'b0;
    logic bit_in  = 1'b0;
    logic frame   = 1'b0;
    logic lamp_high;
    logic lamp_warn;

    always #10 clk = ~clk;

    fir_level_lamps #(
        .NUM_TAPS   (NT),
        .INNER_COEF (INNER)
    ) i_fir_level_lamps (
        .clk       (clk),
        .rst       (rst),
        .bit_clk   (bit_clk),
        .bit_in    (bit_in),
        .frame     (frame),
        .lamp_high (lamp_high),
        .lamp_warn (lamp_warn)
    );

    int         checks   = 0;
    int         failures = 0;
    int         hist [NT];
    logic [9:0] sh_model = '0;
    logic       exp_high = 1'b0;
    logic       exp_warn = 1'b1;

    function automatic int ref_coef(input int k);
        int m;
        m = (k < NT - 1 - k) ? k : NT - 1 - k;
        if (m == 0) return 442;
        if (m == 1) return -373;
        if (m == 2) return -169;
        return INNER;
    endfunction

    task automatic check_lamps(input string req, input logic eh, input logic ew);
        checks++;
        if (lamp_high !== eh || lamp_warn !== ew) begin
            failures++;
            $display("FAIL %s: lamps high=%b warn=%b, expected high=%b warn=%b",
                     req, lamp_high, lamp_warn, eh, ew);
        end
    endtask

    task automatic model_push();
        longint acc;
        int     lvl;
        for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = int'(sh_model);
        acc = 0;
        for (int k = 0; k < NT; k++) acc += longint'(ref_coef(k)) * longint'(hist[k]);
        lvl = int'(acc[22:15]);
        if (lvl >= 90 && lvl <= 110) begin
            exp_high = 1'b1; exp_warn = 1'b0;
        end else if (lvl >= 40 && lvl <= 60) begin
            exp_high = 1'b0; exp_warn = 1'b0;
        end else begin
            exp_high = 1'b0; exp_warn = 1'b1;
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_in = b;
        repeat (2) @(negedge clk);
        bit_clk = 1'b1;
        if (frame) sh_model = {b, sh_model[9:1]};
        repeat (3) @(negedge clk);
        bit_clk = 1'b0;
    endtask

    // Drops frame, confirms the lamps hold during the pass (R9), then checks the result.
    task automatic end_frame(input string req);
        logic ph, pw;
        ph = exp_high;
        pw = exp_warn;
        @(negedge clk);
        frame = 1'b0;
        repeat (2) @(negedge clk);
        check_lamps("R9", ph, pw);
        model_push();
        repeat (NT + 8) @(negedge clk);
        check_lamps(req, exp_high, exp_warn);
    endtask

    task automatic send_sample(input logic [9:0] v, input int nbits, input string req);
        @(negedge clk);
        frame = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < nbits; i++) send_bit(v[i]);
        repeat (3) @(negedge clk);
        end_frame(req);
    endtask

    initial begin
        int unsigned seed;
        for (int k = 0; k < NT; k++) hist[k] = 0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state shows the warning lamp only
        check_lamps("R8", 1'b0, 1'b1);

        // Ramp: steady-state level equals sample-4, crossing every window edge
        for (int n = 0; n < 126; n++) send_sample(10'(n), 10, "R3/R4/R5/R7");

        // Constant holds: accumulator must restart each pass
        for (int i = 0; i < NT; i++) send_sample(10'd100, 10, "R5");
        for (int i = 0; i < NT; i++) send_sample(10'd50, 10, "R5");
        for (int i = 0; i < NT; i++) send_sample(10'd1023, 10, "R6");

        // R1: bit clock edges with frame low are ignored, partial frame keeps old bits
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        send_sample(10'b00000_10110, 5, "R1");
        send_sample(10'd97, 10, "R1");

        // R2: a frame without bits still runs one pass on the unchanged register
        @(negedge clk);
        frame = 1'b1;
        repeat (4) @(negedge clk);
        end_frame("R2");
        repeat (40) @(negedge clk);
        check_lamps("R2", exp_high, exp_warn);

        // R10: a second fall during a running pass is not accepted
        @(negedge clk);
        frame = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 10; i++) send_bit(i[0]);
        repeat (3) @(negedge clk);
        frame = 1'b0;
        model_push();
        repeat (3) @(negedge clk);
        frame = 1'b1;
        repeat (3) @(negedge clk);
        frame = 1'b0;
        repeat (NT + 14) @(negedge clk);
        check_lamps("R10", exp_high, exp_warn);
        send_sample(10'd300, 10, "R10");

        // Pseudo-random samples
        seed = 32'd12345;
        for (int i = 0; i < 40; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            send_sample(10'(seed >> 16), 10, "R3/R4/R6/R7");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule